// File: doc/BRIEF.md
# Instruction Length Decoder for 16-bit x86-Class Code

This block sits at the front of an instruction fetch path. It accepts a stream of instruction bytes, one byte for each cycle in which `in_valid` is high, and works out where each instruction ends. It reports the total byte count, the opcode and the ModR/M byte in the same cycle that the final byte of the instruction is accepted. The next byte after that is taken as a fresh opcode, so instructions can follow one another with no gap.

Lengths come from two sources. For an opcode with a fixed length, a per-opcode class gives the number of bytes that follow it. For an opcode that takes a ModR/M byte, the mode and r/m fields of that byte give the displacement size, and the opcode adds any immediate bytes, which come after the displacement. Segment-override and lock prefixes count as independent one-byte instructions. An opcode outside the supported set ends at once with an error flag and a length of one.

Top module: `ild_top`

## Requirements
- R1: While `rst` is high, `in_ready` and `done` are low. After `rst` falls, the first accepted byte is decoded as an opcode.
- R2: Opcodes 0x26, 0x3E, 0x40-0x4F, 0xA6, 0xA7, 0xAE, 0xAF, 0xF0, 0xF4, 0xF5 and 0xF8-0xFD are complete in one byte. `done` is asserted with `len`=1 and `modrm`=0x00.
- R3: Opcodes 0x04, 0x14, 0x24, 0x3C, 0x70-0x7F, 0xCD, 0xE0-0xE7 and 0xEB are 2 bytes long. Opcodes 0x05, 0x15, 0x25, 0x3D, 0xE8 and 0xE9 are 3 bytes long. Opcodes 0x9A and 0xEA are 5 bytes long. For all of these, `modrm` is reported as 0x00.
- R4: Opcodes 0x00-0x03, 0x10-0x13, 0x20-0x23, 0x38-0x3B, 0xF6, 0xF7, 0xFE and 0xFF are followed by a ModR/M byte. The mode field is bits 7:6 and the r/m field is bits 2:0. The number of displacement bytes after the ModR/M byte is 1 for mode 01, 2 for mode 10, 2 for mode 00 with r/m 110, and 0 in every other case.
- R5: Opcodes 0x80 and 0x83 take a ModR/M byte plus one immediate byte. Opcode 0x81 takes a ModR/M byte plus two immediate bytes. The immediate bytes follow any displacement, so the longest instruction is 6 bytes.
- R6: `done` is high only in the cycle that accepts the final byte of an instruction. In that cycle, `len` equals the byte count (1 to 6), `opcode` equals the first byte and `modrm` equals the second byte for ModR/M forms.
- R7: The byte accepted in the cycle after `done` is decoded as a new opcode, with no idle cycle needed.
- R8: Any opcode not listed in R2 to R5 asserts `illegal` together with `done` on that byte, with `len`=1.
- R9: A cycle with `in_valid` low consumes no byte, does not advance the decode and does not assert `done`.
- R10: `in_ready` is high in every cycle in which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction byte is present on `in_byte` |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can accept a byte |
| done | output | 1 | The byte accepted this cycle ends an instruction |
| len | output | 3 | Instruction length in bytes, valid with `done` |
| opcode | output | 8 | Opcode byte, valid with `done` |
| modrm | output | 8 | ModR/M byte, or 0x00 if the instruction has none, valid with `done` |
| illegal | output | 1 | Unsupported opcode, valid with `done` |

## Verification
The bound checker enforces on every cycle that `done` never fires without an accepted byte and that any reported length lies between 1 and 6. It also checks that an illegal opcode always ends with a length of one, that one-byte completions report no ModR/M byte, and that the far-pointer and word-immediate group opcodes report their fixed or minimum lengths. Only the bench's sweep can show that every one of the 256 opcodes is given its exact length under each ModR/M mode and r/m combination. The sweep also shows that `done` appears on exactly the last byte, that instructions sent back to back are split correctly, and that an idle cycle inside an instruction changes nothing.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAX_LEN = 6;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int TAIL_W  = $clog2(MAX_LEN);

    typedef enum logic [1:0] {
        ST_OPC   = 2'd0,
        ST_MODRM = 2'd1,
        ST_TAIL  = 2'd2
    } seq_state_e;

    // Per-opcode class: tail is the byte count after the opcode for plain
    // forms, or the immediate byte count after ModR/M and displacement.
    typedef struct packed {
        logic              legal;
        logic              has_modrm;
        logic [TAIL_W-1:0] tail;
    } op_class_t;

    function automatic op_class_t classify_op(input logic [BYTE_W-1:0] op);
        op_class_t c;
        c = '{legal: 1'b1, has_modrm: 1'b0, tail: '0};
        casez (op)
            8'b00?0_00??, 8'b0001_00??, 8'b0011_10??,
            8'hF6, 8'hF7, 8'hFE, 8'hFF:  c.has_modrm = 1'b1;
            8'h80, 8'h83:                begin c.has_modrm = 1'b1; c.tail = TAIL_W'(1); end
            8'h81:                       begin c.has_modrm = 1'b1; c.tail = TAIL_W'(2); end
            8'h26, 8'h3E, 8'b0100_????, 8'hA6, 8'hA7, 8'hAE, 8'hAF,
            8'hF0, 8'hF4, 8'hF5, 8'b1111_10??, 8'hFC, 8'hFD: c.tail = '0;
            8'h04, 8'h14, 8'h24, 8'h3C, 8'b0111_????,
            8'b1110_0???, 8'hEB, 8'hCD:  c.tail = TAIL_W'(1);
            8'h05, 8'h15, 8'h25, 8'h3D,
            8'hE8, 8'hE9:                c.tail = TAIL_W'(2);
            8'h9A, 8'hEA:                c.tail = TAIL_W'(4);
            default:                     c.legal = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [1:0] disp_count(input logic [BYTE_W-1:0] mr);
        logic [1:0] mode;
        logic [2:0] rm;
        mode = mr[7:6];
        rm   = mr[2:0];
        case (mode)
            2'b01:   return 2'd1;
            2'b10:   return 2'd2;
            2'b00:   return (rm == 3'b110) ? 2'd2 : 2'd0;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
    import ild_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    output op_class_t         op_cls
);
    always_comb op_cls = classify_op(op_byte);
endmodule

// File: rtl/ild_dispcalc.sv
module ild_dispcalc
    import ild_pkg::*;
(
    input  logic [BYTE_W-1:0] mr_byte,
    output logic [1:0]        disp_bytes
);
    always_comb disp_bytes = disp_count(mr_byte);
endmodule

// File: rtl/ild_seq.sv
module ild_seq
    import ild_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  op_class_t         op_cls,
    input  logic [1:0]        disp_bytes,
    output logic              done,
    output logic [LEN_W-1:0]  len,
    output logic [BYTE_W-1:0] opcode,
    output logic [BYTE_W-1:0] modrm,
    output logic              illegal
);
    seq_state_e        st_q, st_n;
    logic [LEN_W-1:0]  cnt_q, cnt_n;
    logic [TAIL_W-1:0] rem_q, rem_n;
    logic [TAIL_W-1:0] imm_q, imm_n;
    logic [BYTE_W-1:0] opc_q, opc_n;
    logic [BYTE_W-1:0] mr_q, mr_n;
    logic [TAIL_W-1:0] after_mr;

    assign after_mr = TAIL_W'(disp_bytes) + imm_q;

    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        rem_n   = rem_q;
        imm_n   = imm_q;
        opc_n   = opc_q;
        mr_n    = mr_q;
        done    = 1'b0;
        illegal = 1'b0;
        len     = cnt_q + LEN_W'(1);
        opcode  = opc_q;
        modrm   = mr_q;
        case (st_q)
            ST_OPC: begin
                opcode = in_byte;
                modrm  = '0;
                len    = LEN_W'(1);
                if (in_valid) begin
                    if (!op_cls.legal) begin
                        done    = 1'b1;
                        illegal = 1'b1;
                    end else if (op_cls.has_modrm) begin
                        st_n  = ST_MODRM;
                        imm_n = op_cls.tail;
                        opc_n = in_byte;
                        cnt_n = LEN_W'(1);
                    end else if (op_cls.tail == '0) begin
                        done = 1'b1;
                    end else begin
                        st_n  = ST_TAIL;
                        rem_n = op_cls.tail;
                        opc_n = in_byte;
                        mr_n  = '0;
                        cnt_n = LEN_W'(1);
                    end
                end
            end
            ST_MODRM: begin
                modrm = in_byte;
                len   = LEN_W'(2);
                if (in_valid) begin
                    mr_n = in_byte;
                    if (after_mr == '0) begin
                        done = 1'b1;
                        st_n = ST_OPC;
                    end else begin
                        st_n  = ST_TAIL;
                        rem_n = after_mr;
                        cnt_n = LEN_W'(2);
                    end
                end
            end
            ST_TAIL: begin
                if (in_valid) begin
                    cnt_n = cnt_q + LEN_W'(1);
                    rem_n = rem_q - TAIL_W'(1);
                    if (rem_q == TAIL_W'(1)) begin
                        done = 1'b1;
                        st_n = ST_OPC;
                    end
                end
            end
            default: st_n = ST_OPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_OPC;
            cnt_q <= '0;
            rem_q <= '0;
            imm_q <= '0;
            opc_q <= '0;
            mr_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            rem_q <= rem_n;
            imm_q <= imm_n;
            opc_q <= opc_n;
            mr_q  <= mr_n;
        end
    end
endmodule

// File: rtl/ild_top.sv
module ild_top
    import ild_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              done,
    output logic [2:0]        len,
    output logic [7:0]        opcode,
    output logic [7:0]        modrm,
    output logic              illegal
);
    op_class_t  cls;
    logic [1:0] dsp;
    logic       acc_valid;

    assign in_ready  = ~rst;
    assign acc_valid = in_valid & ~rst;

    ild_opclass u_cls (
        .op_byte (in_byte),
        .op_cls  (cls)
    );

    ild_dispcalc u_dsp (
        .mr_byte    (in_byte),
        .disp_bytes (dsp)
    );

    ild_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (acc_valid),
        .in_byte    (in_byte),
        .op_cls     (cls),
        .disp_bytes (dsp),
        .done       (done),
        .len        (len),
        .opcode     (opcode),
        .modrm      (modrm),
        .illegal    (illegal)
    );
endmodule

// File: rtl/ild_checker.sv
module ild_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       done,
    input logic [2:0] len,
    input logic [7:0] opcode,
    input logic [7:0] modrm,
    input logic       illegal
);
    assert_len_range_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (len >= 3'd1 && len <= 3'd6));

    assert_done_needs_byte_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !done);

    assert_illegal_single_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && len == 3'd1));

    assert_single_no_modrm_R2: assert property (@(posedge clk) disable iff (rst)
        (done && len == 3'd1) |-> (modrm == 8'h00));

    assert_far_ptr_len_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal && (opcode == 8'hEA || opcode == 8'h9A)) |-> (len == 3'd5));

    assert_word_imm_min_R5: assert property (@(posedge clk) disable iff (rst)
        (done && opcode == 8'h81) |-> (len >= 3'd4));
endmodule

bind ild_top ild_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .done     (done),
    .len      (len),
    .opcode   (opcode),
    .modrm    (modrm),
    .illegal  (illegal)
);

// File: tb/sim_ild_top.sv
module sim_ild_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, done, illegal;
    logic [2:0] len;
    logic [7:0] opcode, modrm;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ild_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .len(len), .opcode(opcode),
        .modrm(modrm), .illegal(illegal)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected length from the requirement lists.
    function automatic int exp_len(input logic [7:0] op, input logic [7:0] mr,
                                   output bit ill, output bit hm);
        int d;
        ill = 1'b0;
        hm  = 1'b0;
        if (op inside {[8'h00:8'h03], [8'h10:8'h13], [8'h20:8'h23], [8'h38:8'h3B],
                       8'hF6, 8'hF7, 8'hFE, 8'hFF, 8'h80, 8'h81, 8'h83}) begin
            hm = 1'b1;
            if (mr[7:6] == 2'b01) d = 1;
            else if (mr[7:6] == 2'b10) d = 2;
            else if (mr[7:6] == 2'b00 && mr[2:0] == 3'b110) d = 2;
            else d = 0;
            if (op == 8'h81) return 4 + d;
            if (op == 8'h80 || op == 8'h83) return 3 + d;
            return 2 + d;
        end
        if (op inside {8'h26, 8'h3E, [8'h40:8'h4F], 8'hA6, 8'hA7, 8'hAE, 8'hAF,
                       8'hF0, 8'hF4, 8'hF5, [8'hF8:8'hFD]}) return 1;
        if (op inside {8'h04, 8'h14, 8'h24, 8'h3C, [8'h70:8'h7F], 8'hCD,
                       [8'hE0:8'hE7], 8'hEB}) return 2;
        if (op inside {8'h05, 8'h15, 8'h25, 8'h3D, 8'hE8, 8'hE9}) return 3;
        if (op inside {8'h9A, 8'hEA}) return 5;
        ill = 1'b1;
        return 1;
    endfunction

    // Sends one instruction; optional idle cycle after the opcode byte (R9).
    task automatic run_insn(input logic [7:0] op, input logic [7:0] mr, input bit gap);
        bit ill, hm;
        int l;
        l = exp_len(op, mr, ill, hm);
        for (int i = 0; i < l; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            if (i == 0) in_byte = op;
            else if (hm && i == 1) in_byte = mr;
            else in_byte = 8'hC0 + 8'(i);
            #(CLK_PERIOD/4);
            check("R10 ready", int'(in_ready), 1);
            if (i < l - 1) begin
                check("R6 no early done", int'(done), 0);
            end else begin
                check("R6 done on last byte", int'(done), 1);
                if (hm) check("R4/R5 length", int'(len), l);
                else if (ill) check("R8 length", int'(len), l);
                else if (l == 1) check("R2 length", int'(len), l);
                else check("R3 length", int'(len), l);
                check("R6 opcode", int'(opcode), int'(op));
                check("R6 modrm", int'(modrm), hm ? int'(mr) : 0);
                check("R8 illegal", int'(illegal), int'(ill));
            end
            if (gap && i == 0 && l > 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte  = 8'h4F;
                #(CLK_PERIOD/4);
                check("R9 idle no done", int'(done), 0);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog expired: actual hung expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'h26;
        #(CLK_PERIOD/4);
        check("R1 ready low in reset", int'(in_ready), 0);
        check("R1 done low in reset", int'(done), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #(CLK_PERIOD/4);
        check("R10 ready after reset", int'(in_ready), 1);
        check("R9 no done without valid", int'(done), 0);

        // R1: first byte after reset is an opcode (3-byte form)
        run_insn(8'hE8, 8'h00, 1'b0);

        // Sweep all opcodes back to back (R7), ModR/M forms over modes (R4, R5)
        for (int op = 0; op < 256; op++) begin
            bit ill, hm;
            int l;
            l = exp_len(8'(op), 8'h00, ill, hm);
            if (hm) begin
                for (int md = 0; md < 4; md++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [7:0] mr;
                        mr = {2'(md), 3'd5, (k == 0) ? 3'b110 : 3'b011};
                        run_insn(8'(op), mr, (op == 8'h81 && md == 2));
                    end
                end
            end else begin
                run_insn(8'(op), 8'h00, (op == 8'hEA));
            end
        end

        // Longest case followed at once by a prefix (R5, R7)
        run_insn(8'h81, 8'h86, 1'b0);
        run_insn(8'h3E, 8'h00, 1'b0);
        run_insn(8'h83, 8'h06, 1'b1);

        @(negedge clk);
        in_valid = 1'b0;
        #(CLK_PERIOD/4);
        check("R9 idle after stream", int'(done), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule